// File: doc/BRIEF.md
# Parallel Flash Identification Probe

This block is a small bus master that finds out whether a 16-bit parallel NOR flash sits on its port. When started, it switches the device into its query mode and reads back a short, fixed identification string from the query table. It then reads the manufacturer code and the device code and compares each value it reads with the value it expects. The expected codes are parameters.

The probe drives a simple synchronous flash port. This port has a byte address, write data, a write strobe, a read strobe and read data. Read data is sampled a parameterized number of cycles after the read strobe. The first value that differs from what is expected ends the probe at once, and no further bus access is made. Only a fully matching device is switched back to normal array reads before the result is reported. A system uses the block once after reset, or whenever it needs to know which device is attached: it pulses `start`, waits for `done`, and reads the two result flags.

Top module: `flash_id_probe`

## Requirements
- R1: In the cycle after `start` is seen while idle, the probe makes one write of 0x0098 to byte address 0.
- R2: Next it reads the query string at byte addresses 0x20, 0x22, 0x24, 0x26, 0x28, 0x2A, 0x2C, in that order. It expects 0x0051, 0x0052, 0x0059, 0x0001, 0x0000, 0x0031, 0x0000.
- R3: After the string it reads byte address 0x00 and expects the manufacturer code 0x0089. It then reads byte address 0x02 and expects the device code 0x0018.
- R4: Each read strobe lasts exactly one cycle. Read data is sampled at the clock edge that ends the cycle RD_LAT cycles after the strobe cycle. The next read strobe follows in the cycle after that, so successive reads are RD_LAT+1 cycles apart.
- R5: A read matches only when all 16 bits are equal. A correct low byte with a non-zero upper byte counts as a mismatch.
- R6: The first mismatching read ends the probe. No further read or write is made, `done` pulses, and `id_mismatch` is set.
- R7: When all nine reads match, the probe writes 0x00FF to byte address 0 and, in the next cycle, pulses `done` with `id_match` set.
- R8: `done` is high for exactly one cycle per probe. At that point exactly one of `id_match` and `id_mismatch` is high. The flags hold until the next accepted `start`, which clears both.
- R9: A `start` pulse while a probe is running is ignored. The access sequence and the single `done` are unchanged.
- R10: During reset and after it, `done`, `id_match`, `id_mismatch`, `fl_wr` and `fl_rd` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a probe when idle |
| done | output | 1 | One-cycle pulse at the end of a probe |
| id_match | output | 1 | Last probe found the expected device |
| id_mismatch | output | 1 | Last probe stopped on a differing read |
| fl_addr | output | ADDR_W | Flash byte address |
| fl_wdata | output | DATA_W | Flash write data |
| fl_wr | output | 1 | Flash write strobe |
| fl_rd | output | 1 | Flash read strobe |
| fl_rdata | input | DATA_W | Flash read data |

## Verification
Some rules hold on every cycle, and the assertions check those: the two strobes are never active together, writes go only to address 0, reads are halfword-aligned and never back to back, and `done` is a single pulse that carries exactly one flag. They also check that there is no bus traffic while a failure is reported, and that a match is always preceded by the write that restores array mode. Other properties concern a whole probe, and only the bench scenarios can show them. These are the exact order of addresses, the sampling cycle set by the read latency, the full-width comparison, and the point at which a corrupted entry in each position cuts the sequence short. The bench scenarios also show that a second `start` during a probe has no effect.

// File: rtl/flash_probe_pkg.sv
package flash_probe_pkg;

   typedef enum logic [2:0] {
      PS_IDLE,
      PS_QCMD,
      PS_READ,
      PS_WAIT,
      PS_EXIT,
      PS_DONE
   } probe_state_t;

   localparam int unsigned STR_LEN   = 7;
   localparam int unsigned NUM_READS = STR_LEN + 2;
   localparam int unsigned STEP_W    = $clog2(NUM_READS);

   localparam logic [7:0] CMD_ENTER_QUERY = 8'h98;
   localparam logic [7:0] CMD_READ_ARRAY  = 8'hFF;
   localparam logic [7:0] QUERY_WORD_BASE = 8'h10;

   // expected low byte of query string entry idx
   function automatic logic [7:0] query_byte(input logic [STEP_W-1:0] idx);
      logic [7:0] b;
      case (idx)
         4'd0:    b = 8'h51;
         4'd1:    b = 8'h52;
         4'd2:    b = 8'h59;
         4'd3:    b = 8'h01;
         4'd5:    b = 8'h31;
         default: b = 8'h00;
      endcase
      return b;
   endfunction

endpackage

// File: rtl/flash_probe_seq.sv
module flash_probe_seq
   import flash_probe_pkg::*;
#(
   parameter int unsigned ADDR_W   = 8,
   parameter logic [7:0]  MFR_CODE = 8'h89,
   parameter logic [7:0]  DEV_CODE = 8'h18
) (
   input  logic [STEP_W-1:0] step,
   output logic [ADDR_W-1:0] rd_addr,
   output logic [7:0]        expect_byte,
   output logic              last_step
);

   localparam int unsigned WIDX_W = 9;

   logic [WIDX_W-1:0] word_idx;

   always_comb begin
      word_idx    = {1'b0, QUERY_WORD_BASE} + WIDX_W'(step);
      rd_addr     = '0;
      expect_byte = '0;
      if (step < STEP_W'(STR_LEN)) begin
         rd_addr     = ADDR_W'({word_idx, 1'b0});
         expect_byte = query_byte(step);
      end else if (step == STEP_W'(STR_LEN)) begin
         rd_addr     = ADDR_W'(0);
         expect_byte = MFR_CODE;
      end else begin
         rd_addr     = ADDR_W'(2);
         expect_byte = DEV_CODE;
      end
      last_step = (step == STEP_W'(NUM_READS - 1));
   end

endmodule

// File: rtl/flash_probe_timer.sv
module flash_probe_timer #(
   parameter int unsigned LAT = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic expired
);

   generate
      if (LAT == 1) begin : g_direct
         assign expired = 1'b1;
      end else begin : g_count
         localparam int unsigned CNT_W = $clog2(LAT + 1);
         logic [CNT_W-1:0] cnt;
         always_ff @(posedge clk) begin
            if (!rst_n)
               cnt <= '0;
            else if (load)
               cnt <= CNT_W'(LAT - 1);
            else if (cnt != '0)
               cnt <= cnt - 1'b1;
         end
         assign expired = (cnt == '0);
      end
   endgenerate

endmodule

// File: rtl/flash_id_probe.sv
module flash_id_probe
   import flash_probe_pkg::*;
#(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned RD_LAT   = 2,
   parameter logic [7:0]  MFR_CODE = 8'h89,
   parameter logic [7:0]  DEV_CODE = 8'h18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              done,
   output logic              id_match,
   output logic              id_mismatch,
   output logic [ADDR_W-1:0] fl_addr,
   output logic [DATA_W-1:0] fl_wdata,
   output logic              fl_wr,
   output logic              fl_rd,
   input  logic [DATA_W-1:0] fl_rdata
);

   if (ADDR_W < 6) begin : g_chk_addr
      $error("flash_id_probe: ADDR_W must reach byte address 0x2C");
   end
   if (DATA_W < 9) begin : g_chk_data
      $error("flash_id_probe: DATA_W must exceed one byte");
   end
   if (RD_LAT < 1) begin : g_chk_lat
      $error("flash_id_probe: RD_LAT must be at least 1");
   end

   probe_state_t      state;
   logic [STEP_W-1:0] step;
   logic [ADDR_W-1:0] seq_addr;
   logic [7:0]        exp_byte;
   logic              last_step;
   logic              lat_done;
   logic              word_ok;

   flash_probe_seq #(
      .ADDR_W  (ADDR_W),
      .MFR_CODE(MFR_CODE),
      .DEV_CODE(DEV_CODE)
   ) u_seq (
      .step       (step),
      .rd_addr    (seq_addr),
      .expect_byte(exp_byte),
      .last_step  (last_step)
   );

   flash_probe_timer #(
      .LAT(RD_LAT)
   ) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (state == PS_READ),
      .expired(lat_done)
   );

   assign word_ok = (fl_rdata == {{(DATA_W-8){1'b0}}, exp_byte});

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state       <= PS_IDLE;
         step        <= '0;
         id_match    <= 1'b0;
         id_mismatch <= 1'b0;
      end else begin
         case (state)
            PS_IDLE: if (start) begin
               state       <= PS_QCMD;
               step        <= '0;
               id_match    <= 1'b0;
               id_mismatch <= 1'b0;
            end
            PS_QCMD: state <= PS_READ;
            PS_READ: state <= PS_WAIT;
            PS_WAIT: if (lat_done) begin
               if (!word_ok) begin
                  id_mismatch <= 1'b1;
                  state       <= PS_DONE;
               end else if (last_step) begin
                  state <= PS_EXIT;
               end else begin
                  step  <= step + 1'b1;
                  state <= PS_READ;
               end
            end
            PS_EXIT: begin
               id_match <= 1'b1;
               state    <= PS_DONE;
            end
            PS_DONE: state <= PS_IDLE;
            default: state <= PS_IDLE;
         endcase
      end
   end

   always_comb begin
      fl_wr    = (state == PS_QCMD) || (state == PS_EXIT);
      fl_rd    = (state == PS_READ);
      fl_addr  = fl_rd ? seq_addr : '0;
      fl_wdata = '0;
      if (state == PS_QCMD)
         fl_wdata = DATA_W'(CMD_ENTER_QUERY);
      else if (state == PS_EXIT)
         fl_wdata = DATA_W'(CMD_READ_ARRAY);
      done = (state == PS_DONE);
   end

endmodule

// File: rtl/flash_id_probe_chk.sv
module flash_id_probe_chk #(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              done,
   input logic              id_match,
   input logic              id_mismatch,
   input logic [ADDR_W-1:0] fl_addr,
   input logic [DATA_W-1:0] fl_wdata,
   input logic              fl_wr,
   input logic              fl_rd
);

   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(fl_wr && fl_rd)); // R4

   AST_WRITE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      fl_wr |-> (fl_addr == '0)); // R1

   AST_READ_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      fl_rd |-> !fl_addr[0]); // R2

   AST_READ_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
      fl_rd |=> !fl_rd); // R4

   AST_QUIET_ON_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
      id_mismatch |-> (!fl_rd && !fl_wr)); // R6

   AST_RESTORE_BEFORE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(id_match) |-> ($past(fl_wr) && $past(fl_wdata) == DATA_W'(8'hFF))); // R7

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R8

   AST_DONE_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (id_match != id_mismatch)); // R8

endmodule

bind flash_id_probe flash_id_probe_chk #(
   .ADDR_W(ADDR_W),
   .DATA_W(DATA_W)
) u_chk (.*);

// File: tb/flash_id_probe_test.sv
`timescale 1ns/1ps
module flash_id_probe_test;

   localparam int unsigned ADDR_W = 8;
   localparam int unsigned DATA_W = 16;
   localparam int unsigned RD_LAT = 2;
   localparam int          NONE   = 9;
   localparam int          TR_MAX = 64;

   typedef struct packed {
      logic [3:0]  bad_step;
      logic [15:0] bad_val;
   } vec_t;

   // corrupt one read position (9 = none) with the given value
   localparam vec_t VECS [8] = '{
      '{4'd9, 16'h0000},
      '{4'd0, 16'h0071},
      '{4'd2, 16'hFF59},
      '{4'd3, 16'h0002},
      '{4'd6, 16'h0100},
      '{4'd7, 16'h0088},
      '{4'd8, 16'h0118},
      '{4'd5, 16'h0030}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic              done, id_match, id_mismatch, fl_wr, fl_rd;
   logic [ADDR_W-1:0] fl_addr;
   logic [DATA_W-1:0] fl_wdata, fl_rdata;

   always #2.5 clk = ~clk;

   flash_id_probe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RD_LAT(RD_LAT)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .done(done),
      .id_match(id_match), .id_mismatch(id_mismatch),
      .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_wr(fl_wr), .fl_rd(fl_rd),
      .fl_rdata(fl_rdata)
   );

   int checks = 0;
   int errors = 0;
   int cycle = 0;

   always @(posedge clk) cycle <= cycle + 1;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] step_addr(input int s);
      if (s < 7) return 8'(8'h20 + 2 * s);
      return (s == 7) ? 8'h00 : 8'h02;
   endfunction

   function automatic logic [15:0] step_exp(input int s);
      case (s)
         0: return 16'h0051;
         1: return 16'h0052;
         2: return 16'h0059;
         3: return 16'h0001;
         5: return 16'h0031;
         7: return 16'h0089;
         8: return 16'h0018;
         default: return 16'h0000;
      endcase
   endfunction

   // flash model: query mode, one corruptible entry, exact-latency data window
   logic        query_mode = 1'b0;
   int          bad_step = NONE;
   logic [15:0] bad_val = '0;
   logic [RD_LAT:0] pv = '0;
   logic [15:0]     pd [RD_LAT+1];

   function automatic logic [15:0] model_val(input logic [7:0] a, input logic qm,
                                             input int bs, input logic [15:0] bv);
      if (!qm) return 16'hFFFF;
      for (int s = 0; s < 9; s++)
         if (step_addr(s) == a) return (s == bs) ? bv : step_exp(s);
      return 16'h0000;
   endfunction

   assign fl_rdata = pv[RD_LAT] ? pd[RD_LAT] : 16'hDEAD;

   // access trace
   logic        tr_wr   [TR_MAX];
   logic [7:0]  tr_addr [TR_MAX];
   logic [15:0] tr_data [TR_MAX];
   int          tr_cyc  [TR_MAX];
   int          n_tr = 0;
   int          done_cnt = 0;

   always @(negedge clk) begin
      pd[0] <= model_val(fl_addr, query_mode, bad_step, bad_val);
      for (int k = 1; k <= RD_LAT; k++) pd[k] <= pd[k-1];
      pv <= {pv[RD_LAT-1:0], fl_rd};
      if (fl_wr) begin
         if (fl_wdata == 16'h0098) query_mode <= 1'b1;
         else if (fl_wdata == 16'h00FF) query_mode <= 1'b0;
      end
      if ((fl_wr || fl_rd) && n_tr < TR_MAX) begin
         tr_wr[n_tr]   <= fl_wr;
         tr_addr[n_tr] <= fl_addr;
         tr_data[n_tr] <= fl_wdata;
         tr_cyc[n_tr]  <= cycle;
         n_tr          <= n_tr + 1;
      end
      if (done) done_cnt <= done_cnt + 1;
   end

   task automatic run_probe(input int bs, input logic [15:0] bv, input bit restart);
      int  nreads;
      int  guard;
      bit  ok;
      bad_step = bs;
      bad_val  = bv;
      @(negedge clk);
      n_tr = 0;
      done_cnt = 0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(fl_wr && fl_addr == 8'h00 && fl_wdata == 16'h0098, "R1",
          "query entry write", {fl_wr, 7'd0, fl_addr, fl_wdata}, 32'h8000_0098);
      guard = 0;
      while (done_cnt == 0 && guard < 500) begin
         if (restart && guard == 4) start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         guard++;
      end
      repeat (8) @(negedge clk);
      ok     = (bs == NONE);
      nreads = ok ? 9 : bs + 1;
      chk(n_tr == 1 + nreads + (ok ? 1 : 0), ok ? "R7" : "R6",
          "access count", n_tr, 1 + nreads + (ok ? 1 : 0));
      chk(tr_wr[0] && tr_data[0] == 16'h0098, "R1", "first access",
          tr_data[0], 16'h0098);
      for (int i = 0; i < nreads; i++) begin
         chk(!tr_wr[1+i] && tr_addr[1+i] == step_addr(i), (i < 7) ? "R2" : "R3",
             $sformatf("read %0d address", i), tr_addr[1+i], step_addr(i));
      end
      if (ok) begin
         chk(tr_wr[10] && tr_addr[10] == 8'h00 && tr_data[10] == 16'h00FF, "R7",
             "restore write", tr_data[10], 16'h00FF);
         for (int i = 1; i < 9; i++)
            chk(tr_cyc[i+1] - tr_cyc[i] == RD_LAT + 1, "R4", "read spacing",
                tr_cyc[i+1] - tr_cyc[i], RD_LAT + 1);
      end
      chk(id_match == ok && id_mismatch == !ok, (bv[15:8] != 0) ? "R5" : (ok ? "R7" : "R6"),
          "result flags", {id_match, id_mismatch}, {ok, !ok});
      chk(done_cnt == 1, restart ? "R9" : "R8", "done pulses", done_cnt, 1);
   endtask

   initial begin
      #(5.0 * 100000);
      errors++;
      $display("FAIL watchdog R1..: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk({done, id_match, id_mismatch, fl_wr, fl_rd} == 5'b0, "R10",
          "outputs in reset", {done, id_match, id_mismatch, fl_wr, fl_rd}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk({done, id_match, id_mismatch, fl_wr, fl_rd} == 5'b0, "R10",
          "outputs after reset", {done, id_match, id_mismatch, fl_wr, fl_rd}, 0);

      for (int v = 0; v < 8; v++)
         run_probe(int'(VECS[v].bad_step), VECS[v].bad_val, 1'b0);

      // R8: flags hold, then clear on next accepted start
      run_probe(NONE, 16'h0, 1'b0);
      repeat (10) @(negedge clk);
      chk(id_match && !id_mismatch, "R8", "flags held", {id_match, id_mismatch}, 2'b10);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(!id_match && !id_mismatch, "R8", "flags cleared on start",
          {id_match, id_mismatch}, 0);
      repeat (40) @(negedge clk);

      // R9: extra start during a running probe
      run_probe(NONE, 16'h0, 1'b1);
      run_probe(4, 16'h0004, 1'b1);

      // R10: reset in the middle of a probe
      bad_step = NONE;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (6) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk({done, id_match, id_mismatch, fl_wr, fl_rd} == 5'b0, "R10",
          "outputs after mid-probe reset", {done, id_match, id_mismatch, fl_wr, fl_rd}, 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk({done, fl_wr, fl_rd} == 3'b0, "R10", "idle after reset release",
          {done, fl_wr, fl_rd}, 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule